// File: doc/BRIEF.md
# LCD Display Timing Controller

This block generates the raster timing for one parallel RGB panel channel. A pixel counter and a line counter step through the totals held in a small register file. From them the block derives horizontal sync, vertical sync and data-enable, gated by a global enable bit and a channel enable bit. A separate register drives the high-impedance controls for the panel pins, and a sticky vertical-blank flag drives an interrupt line.

A host programs the block over a simple 32-bit register bus. The bus address is the word index, which is the byte offset divided by 4, in a space that ends at byte offset 0x800. Timing fields are double-buffered. While the channel is stopped, a write takes effect on the next clock. While it runs, a write is held until the current frame ends. After enable, a programmable number of whole idle lines passes before the first frame starts.

Top module: `lcd_timing_ctrl`

## Requirements
- R1: Registers sit at word indices 0 CTRL, 1 IRQ, 2 HIZ, 3 POL, 4 ACT, 5 HTIM, 6 VTIM, 7 SYNC. Read data is combinational on the address and returns the last value written to each field, with all undefined bits 0. Any other index reads 0 and ignores writes. Layouts: CTRL has channel enable at bit 0, global enable at bit 4 and the start delay at [20:16]. IRQ has the interrupt enable at bit 0 and the blank flag at bit 16. HIZ holds [PIN_W-1:0]. POL has the hsync invert at bit 0 and the vsync invert at bit 1. ACT has width at [11:0] and height at [27:16]. HTIM has the line total at [11:0] and the horizontal porch at [27:16]. VTIM has the half-line total at [12:0] and the vertical porch at [27:16]. SYNC has the hsync width at [11:0] and the vsync width at [27:16].
- R2: Timing runs only while CTRL bit 0 and bit 4 are both 1. If either is 0 in a cycle, data-enable is 0 from the next cycle on, both syncs sit at their inactive level, and both counters restart from zero.
- R3: A line lasts max(line total, 1) clocks. Hsync is active during the first hsync-width clocks of each line.
- R4: Data-enable is 1 only when the pixel index lies in [porch, porch + width) and the line index lies in [vertical porch, vertical porch + height). Both porch fields include the sync width.
- R5: A frame holds ceil(half-line total / 2) lines, so progressive timing programs twice the line count. Vsync is active during the first vsync-width lines of each frame.
- R6: With a POL bit set, the matching sync output is inverted. Its inactive level, which it also holds while stopped, is then 1.
- R7: When enabled, the block first waits min(start delay, 30) lines of line-total clocks with outputs inactive. The first frame then begins, so a delay of 31 behaves as 30.
- R8: The blank flag is set on the first clock of line (vertical porch + height) and stays set. A write to IRQ with bit 16 at 0 clears it, and a write with bit 16 at 1 leaves it unchanged. A set in the same cycle wins. The interrupt output is the flag ANDed with the enable bit.
- R9: After reset, HIZ is all ones and drives the pin high-impedance outputs directly, while CTRL, IRQ and the outputs read 0.
- R10: POL, ACT, HTIM, VTIM and SYNC writes reach the timing logic at the end of the current frame while running, and on the next clock while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busWordAddr | input | WADDR_W | Register word index |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busWordAddr |
| hsyncOut | output | 1 | Horizontal sync |
| vsyncOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data enable |
| pinHiZ | output | PIN_W | Per-pin high-impedance control, 1 = released |
| vblankIrq | output | 1 | Vertical-blank interrupt |

## Verification
The bench builds the block with its default widths: 12-bit counters, 28 pin controls and a 9-bit word address. It programs deliberately tiny rasters of 10 to 12 clocks per line and 7 to 8 lines per frame. This brings many complete frames, frame-boundary reloads, blank-flag races and the clamped 30-line start delay into a few thousand cycles. A behavioural model then tracks sync, enable, interrupt and readback on every clock. An odd half-line total exercises the rounded-up line count.

// File: rtl/lcd_tc_pkg.sv
`timescale 1ns/1ps
package lcd_tc_pkg;
  localparam int R_CTRL = 0;
  localparam int R_IRQ  = 1;
  localparam int R_HIZ  = 2;
  localparam int R_POL  = 3;
  localparam int R_ACT  = 4;
  localparam int R_HTIM = 5;
  localparam int R_VTIM = 6;
  localparam int R_SYNC = 7;

  localparam int B_CHAN  = 0;
  localparam int B_GLOB  = 4;
  localparam int DLY_LSB = 16;
  localparam int DLY_W   = 5;
  localparam int DLY_MAX = 30;
  localparam int B_IRQEN = 0;
  localparam int B_FLAG  = 16;
  localparam int HI_LSB  = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} tcState_t;

  // control -> datapath
  typedef struct packed {
    logic clear;
    logic hRun;
    logic vRun;
    logic loadShadow;
  } tcStrobe_t;

  // datapath -> control / registers
  typedef struct packed {
    logic lineEnd;
    logic frameEnd;
    logic blankStart;
  } tcEvent_t;
endpackage

// File: rtl/lcd_tc_regs.sv
`timescale 1ns/1ps
module lcd_tc_regs
  import lcd_tc_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int PIN_W   = 28,
  parameter int WADDR_W = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [WADDR_W-1:0] wordAddr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic               loadShadow,
  input  logic               blankStart,
  output logic               enBoth,
  output logic [DLY_W-1:0]   startDelay,
  output logic               irqFlag,
  output logic               irqOut,
  output logic [PIN_W-1:0]   hiZ,
  output logic [CNT_W-1:0]   shHTotal,
  output logic [CNT_W-1:0]   shHBp,
  output logic [CNT_W-1:0]   shHSw,
  output logic [CNT_W-1:0]   shActW,
  output logic [CNT_W:0]     shVTotal,
  output logic [CNT_W-1:0]   shVBp,
  output logic [CNT_W-1:0]   shVSw,
  output logic [CNT_W-1:0]   shActH,
  output logic               shHInv,
  output logic               shVInv
);
  logic chanEn, globEn, irqEn;
  logic [DLY_W-1:0] dlyField;
  logic [PIN_W-1:0] hiZReg;
  logic [1:0] polReg;
  logic [CNT_W-1:0] pHTotal, pHBp, pHSw, pActW, pVBp, pVSw, pActH;
  logic [CNT_W:0] pVTotal;
  logic wrCtrl, wrIrq, wrHiZ, wrPol, wrAct, wrHTim, wrVTim, wrSync;
  logic unusedBus;

  assign unusedBus = ^wrData;

  assign wrCtrl = wrEn && (wordAddr == WADDR_W'(R_CTRL));
  assign wrIrq  = wrEn && (wordAddr == WADDR_W'(R_IRQ));
  assign wrHiZ  = wrEn && (wordAddr == WADDR_W'(R_HIZ));
  assign wrPol  = wrEn && (wordAddr == WADDR_W'(R_POL));
  assign wrAct  = wrEn && (wordAddr == WADDR_W'(R_ACT));
  assign wrHTim = wrEn && (wordAddr == WADDR_W'(R_HTIM));
  assign wrVTim = wrEn && (wordAddr == WADDR_W'(R_VTIM));
  assign wrSync = wrEn && (wordAddr == WADDR_W'(R_SYNC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanEn <= 1'b0; globEn <= 1'b0; dlyField <= '0;
      irqEn <= 1'b0; irqFlag <= 1'b0;
      hiZReg <= '1; polReg <= '0;
      pHTotal <= '0; pHBp <= '0; pHSw <= '0; pActW <= '0;
      pVTotal <= '0; pVBp <= '0; pVSw <= '0; pActH <= '0;
    end else begin
      if (wrCtrl) begin
        chanEn   <= wrData[B_CHAN];
        globEn   <= wrData[B_GLOB];
        dlyField <= wrData[DLY_LSB +: DLY_W];
      end
      if (wrIrq) irqEn <= wrData[B_IRQEN];
      irqFlag <= blankStart | (irqFlag & ~(wrIrq & ~wrData[B_FLAG]));
      if (wrHiZ) hiZReg <= wrData[PIN_W-1:0];
      if (wrPol) polReg <= wrData[1:0];
      if (wrAct) begin
        pActW <= wrData[CNT_W-1:0];
        pActH <= wrData[HI_LSB +: CNT_W];
      end
      if (wrHTim) begin
        pHTotal <= wrData[CNT_W-1:0];
        pHBp    <= wrData[HI_LSB +: CNT_W];
      end
      if (wrVTim) begin
        pVTotal <= wrData[CNT_W:0];
        pVBp    <= wrData[HI_LSB +: CNT_W];
      end
      if (wrSync) begin
        pHSw <= wrData[CNT_W-1:0];
        pVSw <= wrData[HI_LSB +: CNT_W];
      end
    end
  end

  // frame-boundary copy seen by the timing datapath
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shHTotal <= '0; shHBp <= '0; shHSw <= '0; shActW <= '0;
      shVTotal <= '0; shVBp <= '0; shVSw <= '0; shActH <= '0;
      shHInv <= 1'b0; shVInv <= 1'b0;
    end else if (loadShadow) begin
      shHTotal <= pHTotal; shHBp <= pHBp; shHSw <= pHSw; shActW <= pActW;
      shVTotal <= pVTotal; shVBp <= pVBp; shVSw <= pVSw; shActH <= pActH;
      shHInv <= polReg[0]; shVInv <= polReg[1];
    end
  end

  always_comb begin
    rdData = '0;
    case (wordAddr)
      WADDR_W'(R_CTRL): begin
        rdData[B_CHAN] = chanEn;
        rdData[B_GLOB] = globEn;
        rdData[DLY_LSB +: DLY_W] = dlyField;
      end
      WADDR_W'(R_IRQ): begin
        rdData[B_IRQEN] = irqEn;
        rdData[B_FLAG]  = irqFlag;
      end
      WADDR_W'(R_HIZ):  rdData[PIN_W-1:0] = hiZReg;
      WADDR_W'(R_POL):  rdData[1:0] = polReg;
      WADDR_W'(R_ACT):  begin rdData[CNT_W-1:0] = pActW;   rdData[HI_LSB +: CNT_W] = pActH; end
      WADDR_W'(R_HTIM): begin rdData[CNT_W-1:0] = pHTotal; rdData[HI_LSB +: CNT_W] = pHBp;  end
      WADDR_W'(R_VTIM): begin rdData[CNT_W:0]   = pVTotal; rdData[HI_LSB +: CNT_W] = pVBp;  end
      WADDR_W'(R_SYNC): begin rdData[CNT_W-1:0] = pHSw;    rdData[HI_LSB +: CNT_W] = pVSw;  end
      default: rdData = '0;
    endcase
  end

  assign enBoth     = chanEn & globEn;
  assign startDelay = dlyField;
  assign irqOut     = irqFlag & irqEn;
  assign hiZ        = hiZReg;
endmodule

// File: rtl/lcd_tc_ctrl.sv
`timescale 1ns/1ps
module lcd_tc_ctrl
  import lcd_tc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enBoth,
  input  logic [DLY_W-1:0] startDelay,
  input  tcEvent_t         ev,
  output tcStrobe_t        strobe
);
  tcState_t state;
  logic [DLY_W-1:0] dlyClamp, dlyLim, waitCnt;

  assign dlyClamp = (startDelay > DLY_W'(DLY_MAX)) ? DLY_W'(DLY_MAX) : startDelay;

  always_comb begin
    strobe.clear      = (state == ST_IDLE);
    strobe.hRun       = (state != ST_IDLE);
    strobe.vRun       = (state == ST_RUN);
    strobe.loadShadow = (state == ST_IDLE) || ((state == ST_RUN) && ev.frameEnd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      dlyLim  <= '0;
      waitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (enBoth) begin
          dlyLim  <= dlyClamp;
          waitCnt <= '0;
          state   <= (dlyClamp == '0) ? ST_RUN : ST_WAIT;
        end
        ST_WAIT: begin
          if (!enBoth) state <= ST_IDLE;
          else if (ev.lineEnd) begin
            if (waitCnt == dlyLim - DLY_W'(1)) state <= ST_RUN;
            else waitCnt <= waitCnt + DLY_W'(1);
          end
        end
        ST_RUN: if (!enBoth) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_tc_dp.sv
`timescale 1ns/1ps
module lcd_tc_dp
  import lcd_tc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  tcStrobe_t        strobe,
  input  logic [CNT_W-1:0] hTotal,
  input  logic [CNT_W-1:0] hBp,
  input  logic [CNT_W-1:0] hSw,
  input  logic [CNT_W-1:0] actW,
  input  logic [CNT_W:0]   vTotal,
  input  logic [CNT_W-1:0] vBp,
  input  logic [CNT_W-1:0] vSw,
  input  logic [CNT_W-1:0] actH,
  input  logic             hInv,
  input  logic             vInv,
  output tcEvent_t         ev,
  output logic [CNT_W-1:0] hCnt,
  output logic [CNT_W-1:0] vCnt,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             deOut
);
  logic [CNT_W:0] hNext, vNext, hEnd, vEnd;
  logic [CNT_W+1:0] vHalf;
  logic hLast, vLast, hWin, vWin;

  assign hNext = {1'b0, hCnt} + (CNT_W+1)'(1);
  assign vNext = {1'b0, vCnt} + (CNT_W+1)'(1);
  assign vHalf = {1'b0, vCnt, 1'b0} + (CNT_W+2)'(2);
  assign hLast = hNext >= {1'b0, hTotal};
  assign vLast = vHalf >= {1'b0, vTotal};
  assign hEnd  = {1'b0, hBp} + {1'b0, actW};
  assign vEnd  = {1'b0, vBp} + {1'b0, actH};

  assign ev.lineEnd    = strobe.hRun & hLast;
  assign ev.frameEnd   = strobe.vRun & ev.lineEnd & vLast;
  assign ev.blankStart = strobe.vRun & ev.lineEnd & ~vLast & (vNext == vEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strobe.clear) begin
      hCnt <= '0;
      vCnt <= '0;
    end else begin
      if (strobe.hRun) hCnt <= ev.lineEnd ? '0 : hNext[CNT_W-1:0];
      if (strobe.vRun && ev.lineEnd) vCnt <= vLast ? '0 : vNext[CNT_W-1:0];
    end
  end

  assign hWin = (hCnt >= hBp) && ({1'b0, hCnt} < hEnd);
  assign vWin = (vCnt >= vBp) && ({1'b0, vCnt} < vEnd);

  assign deOut    = strobe.vRun & hWin & vWin;
  assign hsyncOut = (strobe.vRun & (hCnt < hSw)) ^ hInv;
  assign vsyncOut = (strobe.vRun & (vCnt < vSw)) ^ vInv;
endmodule

// File: rtl/lcd_timing_ctrl.sv
`timescale 1ns/1ps
module lcd_timing_ctrl
  import lcd_tc_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int PIN_W   = 28,
  parameter int WADDR_W = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [WADDR_W-1:0] busWordAddr,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               deOut,
  output logic [PIN_W-1:0]   pinHiZ,
  output logic               vblankIrq
);
  tcStrobe_t strobe;
  tcEvent_t ev;
  logic enBoth, irqFlag, shHInv, shVInv;
  logic [DLY_W-1:0] startDelay;
  logic [CNT_W-1:0] shHTotal, shHBp, shHSw, shActW, shVBp, shVSw, shActH, hCnt, vCnt;
  logic [CNT_W:0] shVTotal;

  lcd_tc_regs #(.CNT_W(CNT_W), .PIN_W(PIN_W), .WADDR_W(WADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .wordAddr(busWordAddr),
    .wrData(busWrData), .rdData(busRdData),
    .loadShadow(strobe.loadShadow), .blankStart(ev.blankStart),
    .enBoth(enBoth), .startDelay(startDelay), .irqFlag(irqFlag),
    .irqOut(vblankIrq), .hiZ(pinHiZ),
    .shHTotal(shHTotal), .shHBp(shHBp), .shHSw(shHSw), .shActW(shActW),
    .shVTotal(shVTotal), .shVBp(shVBp), .shVSw(shVSw), .shActH(shActH),
    .shHInv(shHInv), .shVInv(shVInv)
  );

  lcd_tc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enBoth(enBoth), .startDelay(startDelay),
    .ev(ev), .strobe(strobe)
  );

  lcd_tc_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hTotal(shHTotal), .hBp(shHBp), .hSw(shHSw), .actW(shActW),
    .vTotal(shVTotal), .vBp(shVBp), .vSw(shVSw), .actH(shActH),
    .hInv(shHInv), .vInv(shVInv), .ev(ev), .hCnt(hCnt), .vCnt(vCnt),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut)
  );
endmodule

// File: rtl/lcd_tc_checker.sv
`timescale 1ns/1ps
module lcd_tc_checker #(
  parameter int CNT_W   = 12,
  parameter int WADDR_W = 9
) (
  input logic               clk,
  input logic               rstN,
  input logic               enBoth,
  input logic               deOut,
  input logic               vRun,
  input logic               frameEnd,
  input logic [CNT_W-1:0]   hCnt,
  input logic [CNT_W-1:0]   vCnt,
  input logic [CNT_W-1:0]   hTotal,
  input logic [CNT_W:0]     vTotal,
  input logic               flag,
  input logic               wrEn,
  input logic [WADDR_W-1:0] wordAddr,
  input logic               wrFlagBit
);
  // disabled channel blanks data-enable on the following cycle
  p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enBoth |=> !deOut);

  p_hcnt_in_line_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hTotal != '0) |-> (hCnt < hTotal));

  p_vcnt_in_frame_r5: assert property (@(posedge clk) disable iff (!rstN)
    (vTotal != '0) |-> ({1'b0, vCnt, 1'b0} < {1'b0, vTotal}));

  // flag survives any cycle without a clearing write
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !(wrEn && (wordAddr == WADDR_W'(1)) && !wrFlagBit)) |=> flag);

  // mid-frame: timing totals do not move
  p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (vRun && !frameEnd) |=> ($stable(hTotal) && $stable(vTotal)));
endmodule

bind lcd_timing_ctrl lcd_tc_checker #(.CNT_W(CNT_W), .WADDR_W(WADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .enBoth(enBoth), .deOut(deOut),
  .vRun(strobe.vRun), .frameEnd(ev.frameEnd), .hCnt(hCnt), .vCnt(vCnt),
  .hTotal(shHTotal), .vTotal(shVTotal), .flag(irqFlag),
  .wrEn(busWrEn), .wordAddr(busWordAddr), .wrFlagBit(busWrData[16])
);

// File: tb/sim_lcd_timing_ctrl.sv
`timescale 1ns/1ps
module sim_lcd_timing_ctrl;
  localparam int CNT_W = 12;
  localparam int PIN_W = 28;
  localparam int WADDR_W = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [WADDR_W-1:0] busWordAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic hsyncOut, vsyncOut, deOut, vblankIrq;
  logic [PIN_W-1:0] pinHiZ;

  always #4 clk = ~clk;  // 125 MHz

  lcd_timing_ctrl #(.CNT_W(CNT_W), .PIN_W(PIN_W), .WADDR_W(WADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWordAddr(busWordAddr),
    .busWrData(busWrData), .busRdData(busRdData), .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut), .deOut(deOut), .pinHiZ(pinHiZ), .vblankIrq(vblankIrq)
  );

  int vectors = 0;
  int misses = 0;
  bit done = 0;
  string phaseTag = "R9";

  // behavioural reference state
  int mCh, mGl, mDly, mIrqEn, mFlag, mPol;
  int pW, pH, pHT, pHB, pVT, pVB, pHS, pVS;
  int sW, sH, sHT, sHB, sVT, sVB, sHS, sVS, sIH, sIV;
  int mState, hc, vc, wc, dl;
  logic [PIN_W-1:0] mHiZ;

  task automatic modelReset();
    mCh = 0; mGl = 0; mDly = 0; mIrqEn = 0; mFlag = 0; mPol = 0;
    pW = 0; pH = 0; pHT = 0; pHB = 0; pVT = 0; pVB = 0; pHS = 0; pVS = 0;
    sW = 0; sH = 0; sHT = 0; sHB = 0; sVT = 0; sVB = 0; sHS = 0; sVS = 0;
    sIH = 0; sIV = 0; mState = 0; hc = 0; vc = 0; wc = 0; dl = 0;
    mHiZ = '1;
  endtask

  function automatic int modelRead(int idx);
    case (idx)
      0: return mCh | (mGl << 4) | (mDly << 16);
      1: return mIrqEn | (mFlag << 16);
      2: return int'(mHiZ);
      3: return mPol;
      4: return pW | (pH << 16);
      5: return pHT | (pHB << 16);
      6: return pVT | (pVB << 16);
      7: return pHS | (pVS << 16);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      int en, lineEnd, vLast, frameEnd, blank, load, nhc, nvc, ns, d, idx, wrI;
      en = mCh & mGl;
      lineEnd = (mState != 0) && (hc + 1 >= sHT);
      vLast = (2 * vc + 2 >= sVT);
      frameEnd = (mState == 2) && lineEnd && vLast;
      blank = (mState == 2) && lineEnd && !vLast && (vc + 1 == sVB + sH);
      load = (mState == 0) || frameEnd;
      nhc = (mState == 0) ? 0 : (lineEnd ? 0 : hc + 1);
      nvc = (mState == 0) ? 0 : ((mState == 2 && lineEnd) ? (vLast ? 0 : vc + 1) : vc);
      ns = mState;
      case (mState)
        0: if (en) begin
          dl = (mDly > 30) ? 30 : mDly;
          wc = 0;
          ns = (dl == 0) ? 2 : 1;
        end
        1: if (!en) ns = 0;
           else if (lineEnd) begin
             if (wc == dl - 1) ns = 2; else wc = wc + 1;
           end
        default: if (!en) ns = 0;
      endcase
      if (load) begin
        sW = pW; sH = pH; sHT = pHT; sHB = pHB; sVT = pVT; sVB = pVB;
        sHS = pHS; sVS = pVS; sIH = mPol & 1; sIV = (mPol >> 1) & 1;
      end
      d = int'(busWrData);
      idx = int'(busWordAddr);
      wrI = busWrEn && idx == 1;
      mFlag = (blank || (mFlag && !(wrI && ((d >> 16) & 1) == 0))) ? 1 : 0;
      if (busWrEn) begin
        case (idx)
          0: begin mCh = d & 1; mGl = (d >> 4) & 1; mDly = (d >> 16) & 31; end
          1: mIrqEn = d & 1;
          2: mHiZ = busWrData[PIN_W-1:0];
          3: mPol = d & 3;
          4: begin pW = d & 'hFFF; pH = (d >> 16) & 'hFFF; end
          5: begin pHT = d & 'hFFF; pHB = (d >> 16) & 'hFFF; end
          6: begin pVT = d & 'h1FFF; pVB = (d >> 16) & 'hFFF; end
          7: begin pHS = d & 'hFFF; pVS = (d >> 16) & 'hFFF; end
          default: ;
        endcase
      end
      mState = ns; hc = nhc; vc = nvc;
    end
  end

  task automatic cmp(string req, string what, longint act, longint exp);
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s (phase %s) actual=%0h expected=%0h at %0t",
               req, what, phaseTag, act, exp, $time);
    end
  endtask

  // every-cycle comparison, clear of the edge
  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      int expH, expV, expD;
      expH = ((mState == 2 && hc < sHS) ? 1 : 0) ^ sIH;
      expV = ((mState == 2 && vc < sVS) ? 1 : 0) ^ sIV;
      expD = (mState == 2 && hc >= sHB && hc < sHB + sW && vc >= sVB && vc < sVB + sH) ? 1 : 0;
      vectors++;
      cmp("R3", "hsync", hsyncOut, expH);
      cmp("R5", "vsync", vsyncOut, expV);
      cmp("R4", "de", deOut, expD);
      cmp("R8", "irq", vblankIrq, mFlag & mIrqEn);
      cmp("R9", "hiZ", pinHiZ, mHiZ);
      cmp("R1", "rdData", busRdData, modelRead(int'(busWordAddr)));
    end
  end

  task automatic chkx(string req, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(int idx, int d);
    @(negedge clk);
    busWrEn = 1'b1; busWordAddr = WADDR_W'(idx); busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(string req, int idx, longint exp);
    @(negedge clk);
    busWordAddr = WADDR_W'(idx);
    #1;
    chkx(req, "readback", busRdData, exp);
  endtask

  task automatic firstHsync(string req, int exp);
    int n = 1;
    while (hsyncOut !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chkx(req, "cycles to first hsync", n, exp);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      misses++;
      vectors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R9 reset state
    chkx("R9", "hiZ after reset", pinHiZ, {PIN_W{1'b1}});
    chkx("R9", "irq after reset", vblankIrq, 0);
    chkx("R9", "de after reset", deOut, 0);
    rdChk("R9", 0, 0);
    rdChk("R9", 1, 0);

    phaseTag = "R1";
    wr(4, 4 | (3 << 16));
    wr(5, 10 | (3 << 16));
    wr(6, 14 | (2 << 16));
    wr(7, 2 | (1 << 16));
    wr(1, 1);
    rdChk("R1", 5, 10 | (3 << 16));
    rdChk("R1", 6, 14 | (2 << 16));
    @(negedge clk); busWrEn = 1'b1; busWordAddr = 9'h1FF; busWrData = 32'hFFFF_FFFF;
    @(negedge clk); busWrEn = 1'b0;
    rdChk("R1", 'h1FF, 0);

    phaseTag = "R7";
    wr(0, 1 | 16 | (3 << 16));
    firstHsync("R7", 2 + 10 * 3);

    phaseTag = "R4";
    repeat (220) @(negedge clk);

    phaseTag = "R8";
    while (vblankIrq !== 1'b1) @(negedge clk);
    wr(1, 1 | (1 << 16));
    rdChk("R8", 1, 1 | (1 << 16));
    wr(1, 1);
    rdChk("R8", 1, 1);
    chkx("R8", "irq after ack", vblankIrq, 0);

    phaseTag = "R10";
    while (deOut !== 1'b1) @(negedge clk);
    wr(5, 12 | (3 << 16));
    while (vsyncOut !== 1'b1) @(negedge clk);
    while (hsyncOut === 1'b1) @(negedge clk);
    begin
      int n = 0;
      while (hsyncOut === 1'b0 && n < 100) begin @(negedge clk); n++; end
      chkx("R10", "inactive hsync clocks after reload", n, 12 - 2);
    end
    repeat (100) @(negedge clk);

    phaseTag = "R6";
    wr(3, 3);
    repeat (200) @(negedge clk);
    wr(0, 0);
    repeat (3) @(negedge clk);
    chkx("R2", "de after disable", deOut, 0);
    chkx("R6", "inverted idle hsync", hsyncOut, 1);
    chkx("R6", "inverted idle vsync", vsyncOut, 1);

    phaseTag = "R7";
    wr(3, 0);
    wr(0, 1 | 16 | (31 << 16));
    firstHsync("R7", 2 + 12 * 30);

    phaseTag = "R9";
    wr(2, 32'h0F0F0F0);
    repeat (50) @(negedge clk);

    phaseTag = "R5";
    wr(6, 15 | (2 << 16));
    repeat (300) @(negedge clk);

    phaseTag = "R2";
    wr(0, 16);
    repeat (3) @(negedge clk);
    chkx("R2", "de with channel bit clear", deOut, 0);
    chkx("R2", "hsync with channel bit clear", hsyncOut, 0);
    repeat (20) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule